// File: doc/BRIEF.md
# Aliased Multi-View Register File

This block holds sixty-four 32-bit general registers and lets the same storage be read and written through several views. A single-precision float view reaches general registers 0–15 and 32–47 directly. A double-precision view forms a 64-bit value from register n (upper word) and register n+16 (lower word), for n in 0–15 or 32–47. Address generation logic gets two narrow 4-bit ports that return base and index values from general registers 0–15. A further 4-bit port returns modification register m, which is general register 16+m.

All reads are combinational from the stored words. All writes take effect on the rising clock edge, so a read in the same cycle as a write still returns the old contents. Reset is synchronous and clears every register.

None of the ports carries a stream. There is no valid/ready handshake and no back-pressure. Each write is a plain enable qualified by the clock, and each read is a plain address that returns data in the same cycle.

A float or double designator is valid only when its bit 4 is 0. The block reports an invalid designator on a per-port error output. An invalid double write changes nothing.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous reset clears all 64 registers to zero. After one clock edge with `rst` high, every read port returns zero.
- R2: A general write with `gw_en` high stores `gw_data` into register `gw_addr` at the next rising edge. `gr_data` always shows register `gr_addr`, and in the cycle of a write it still shows the old value.
- R3: A float designator `fs_addr` with bit 4 equal to 0 (0–15, 32–47) returns general register `fs_addr` with `fs_err` low. With bit 4 equal to 1 (16–31, 48–63), `fs_err` is high and `fs_data` is zero.
- R4: A valid double designator `dr_addr` (bit 4 equal to 0) returns {register n, register n+16} on `dr_data`, upper word first. An invalid one raises `dr_err` and returns zero.
- R5: A valid double write (`dw_en` high, bit 4 of `dw_addr` equal to 0) stores `dw_data[63:32]` into register n and `dw_data[31:0]` into register n+16 on the same edge. A double read in that cycle returns the old pair.
- R6: When `dw_en` is high with bit 4 of `dw_addr` equal to 1, `dw_err` is high in that cycle and no register changes.
- R7: When a general write and a valid double write hit the same register in one cycle (either the upper or the lower half), that register takes the double-write value.
- R8: `base_data` returns general register `base_addr` and `idx_data` returns general register `idx_addr`, both taken from registers 0–15.
- R9: `mod_data` returns general register 16 + `mod_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gw_en | input | 1 | General write enable |
| gw_addr | input | 6 | General write register number |
| gw_data | input | 32 | General write data |
| gr_addr | input | 6 | General read register number |
| gr_data | output | 32 | General read data |
| fs_addr | input | 6 | Single-precision float designator |
| fs_data | output | 32 | Single-precision float read data |
| fs_err | output | 1 | Float designator invalid |
| dw_en | input | 1 | Double write enable |
| dw_addr | input | 6 | Double write designator |
| dw_data | input | 64 | Double write data, upper word first |
| dw_err | output | 1 | Double write designator invalid |
| dr_addr | input | 6 | Double read designator |
| dr_data | output | 64 | Double read data |
| dr_err | output | 1 | Double read designator invalid |
| base_addr | input | 4 | Base register number |
| base_data | output | 32 | Base register value |
| idx_addr | input | 4 | Index register number |
| idx_data | output | 32 | Index register value |
| mod_addr | input | 4 | Modification register number |
| mod_data | output | 32 | Modification register value (register 16+m) |

## Verification
Every view reads the same storage, so a word that was written to the wrong place shows up on more than one port. A double write that picks the wrong partner register appears on `gr_data` at n+16 (or elsewhere) in the cycle after the edge. A misrouted modification or base mapping shows stale or zero data as soon as its address is presented, because reads are combinational. A write that should have been blocked by a collision or an invalid designator leaves a wrong value that stays until it is overwritten, so reading the register back one cycle later exposes it.

// File: rtl/arf_pkg.sv
package arf_pkg;
  localparam int REG_W    = 32;
  localparam int REG_N    = 64;
  localparam int PAIR_OFS = 16;
  localparam int AW       = $clog2(REG_N);
  localparam int SUB_W    = $clog2(PAIR_OFS);
  localparam int SEL_BIT  = $clog2(PAIR_OFS);

  typedef logic [AW-1:0]      reg_idx_t;
  typedef logic [REG_W-1:0]   word_t;
  typedef logic [2*REG_W-1:0] dword_t;

  // A float/double designator is legal when its pairing bit is clear.
  function automatic logic fp_ok(reg_idx_t a);
    return !a[SEL_BIT];
  endfunction

  // Partner register holding the low word of a double.
  function automatic reg_idx_t pair_lo(reg_idx_t a);
    return a | reg_idx_t'(PAIR_OFS);
  endfunction
endpackage

// File: rtl/arf_store.sv
module arf_store
  import arf_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = REG_N
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  gw_en,
  input  reg_idx_t              gw_addr,
  input  logic [W-1:0]          gw_data,
  input  logic                  dw_go,
  input  reg_idx_t              dw_hi,
  input  reg_idx_t              dw_lo,
  input  logic [2*W-1:0]        dw_data,
  output logic [N-1:0][W-1:0]   words
);
  localparam int IW = $clog2(N);

  logic clash;
  assign clash = dw_go && (gw_addr == dw_hi || gw_addr == dw_lo);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic         hit_hi, hit_lo, hit_gw;
    logic [W-1:0] nxt;
    assign hit_hi = dw_go && (dw_hi == IW'(i));
    assign hit_lo = dw_go && (dw_lo == IW'(i));
    assign hit_gw = gw_en && (gw_addr == IW'(i));

    always_comb begin
      if (hit_hi)      nxt = dw_data[2*W-1:W];
      else if (hit_lo) nxt = dw_data[W-1:0];
      else if (hit_gw) nxt = gw_data;
      else             nxt = words[i];
    end

    always_ff @(posedge clk) begin
      if (rst) words[i] <= '0;
      else     words[i] <= nxt;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (words == '0));

  a_r2_gen_write_lands: assert property (@(posedge clk) disable iff (rst)
    (gw_en && !clash) |=> (words[$past(gw_addr)] == $past(gw_data)));

  a_r5_double_both_halves: assert property (@(posedge clk) disable iff (rst)
    dw_go |=> (words[$past(dw_hi)] == $past(dw_data[2*W-1:W]) &&
               words[$past(dw_lo)] == $past(dw_data[W-1:0])));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!gw_en && !dw_go) |=> $stable(words));
endmodule

// File: rtl/arf_pair_port.sv
module arf_pair_port
  import arf_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = REG_N
) (
  input  logic [N-1:0][W-1:0] words,
  input  reg_idx_t            addr,
  output logic [2*W-1:0]      data,
  output logic                err
);
  logic ok;
  assign ok   = fp_ok(addr);
  assign err  = !ok;
  assign data = ok ? {words[addr], words[pair_lo(addr)]} : '0;
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import arf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gw_en,
  input  logic [AW-1:0]        gw_addr,
  input  logic [REG_W-1:0]     gw_data,
  input  logic [AW-1:0]        gr_addr,
  output logic [REG_W-1:0]     gr_data,
  input  logic [AW-1:0]        fs_addr,
  output logic [REG_W-1:0]     fs_data,
  output logic                 fs_err,
  input  logic                 dw_en,
  input  logic [AW-1:0]        dw_addr,
  input  logic [2*REG_W-1:0]   dw_data,
  output logic                 dw_err,
  input  logic [AW-1:0]        dr_addr,
  output logic [2*REG_W-1:0]   dr_data,
  output logic                 dr_err,
  input  logic [SUB_W-1:0]     base_addr,
  output logic [REG_W-1:0]     base_data,
  input  logic [SUB_W-1:0]     idx_addr,
  output logic [REG_W-1:0]     idx_data,
  input  logic [SUB_W-1:0]     mod_addr,
  output logic [REG_W-1:0]     mod_data
);
  logic [REG_N-1:0][REG_W-1:0] words;
  logic dw_ok, dw_go;

  assign dw_ok  = fp_ok(dw_addr);
  assign dw_go  = dw_en && dw_ok;
  assign dw_err = dw_en && !dw_ok;

  arf_store #(.W(REG_W), .N(REG_N)) store_i (
    .clk     (clk),
    .rst     (rst),
    .gw_en   (gw_en),
    .gw_addr (gw_addr),
    .gw_data (gw_data),
    .dw_go   (dw_go),
    .dw_hi   (dw_addr),
    .dw_lo   (pair_lo(dw_addr)),
    .dw_data (dw_data),
    .words   (words)
  );

  arf_pair_port #(.W(REG_W), .N(REG_N)) dread_i (
    .words (words),
    .addr  (dr_addr),
    .data  (dr_data),
    .err   (dr_err)
  );

  assign gr_data   = words[gr_addr];
  assign fs_err    = !fp_ok(fs_addr);
  assign fs_data   = fs_err ? '0 : words[fs_addr];
  assign base_data = words[AW'(base_addr)];
  assign idx_data  = words[AW'(idx_addr)];
  assign mod_data  = words[AW'(PAIR_OFS) + AW'(mod_addr)];

  a_r6_bad_double_no_change: assert property (@(posedge clk) disable iff (rst)
    (dw_err && !gw_en) |=> $stable(words));

  a_r7_double_beats_general: assert property (@(posedge clk) disable iff (rst)
    (dw_go && gw_en && gw_addr == dw_addr) |=>
      (gr_addr != $past(dw_addr) || gr_data == $past(dw_data[2*REG_W-1:REG_W])));

  a_r3_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    fs_err |-> (fs_data == '0));

  a_r4_dr_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    dr_err |-> (dr_data == '0));
endmodule

// File: tb/alias_regfile_tb_top.sv
module alias_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        gw_en = 0;
  logic [5:0]  gw_addr = 0;
  logic [31:0] gw_data = 0;
  logic [5:0]  gr_addr = 0;
  logic [31:0] gr_data;
  logic [5:0]  fs_addr = 0;
  logic [31:0] fs_data;
  logic        fs_err;
  logic        dw_en = 0;
  logic [5:0]  dw_addr = 0;
  logic [63:0] dw_data = 0;
  logic        dw_err;
  logic [5:0]  dr_addr = 0;
  logic [63:0] dr_data;
  logic        dr_err;
  logic [3:0]  base_addr = 0, idx_addr = 0, mod_addr = 0;
  logic [31:0] base_data, idx_data, mod_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_regfile dut_i (
    .clk(clk), .rst(rst),
    .gw_en(gw_en), .gw_addr(gw_addr), .gw_data(gw_data),
    .gr_addr(gr_addr), .gr_data(gr_data),
    .fs_addr(fs_addr), .fs_data(fs_data), .fs_err(fs_err),
    .dw_en(dw_en), .dw_addr(dw_addr), .dw_data(dw_data), .dw_err(dw_err),
    .dr_addr(dr_addr), .dr_data(dr_data), .dr_err(dr_err),
    .base_addr(base_addr), .base_data(base_data),
    .idx_addr(idx_addr), .idx_data(idx_data),
    .mod_addr(mod_addr), .mod_data(mod_data)
  );

  // {register, value} pairs for the general write/read sweep
  localparam logic [37:0] VEC [8] = '{
    {6'd0,  32'h1111_0000}, {6'd15, 32'hF0F0_0F0F},
    {6'd16, 32'h2222_1616}, {6'd31, 32'hDEAD_BEEF},
    {6'd32, 32'h3333_3232}, {6'd47, 32'h8000_0001},
    {6'd48, 32'h4444_4848}, {6'd63, 32'hFFFF_FFFF}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic gwrite(logic [5:0] a, logic [31:0] d);
    gw_en = 1; gw_addr = a; gw_data = d;
    tick();
    gw_en = 0;
    m[a] = d;
  endtask

  task automatic rd(logic [5:0] a, string tag);
    gr_addr = a; #1;
    chk(tag, {32'h0, gr_data}, {32'h0, m[a]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
    tick(); tick();
    rst = 0;
    // R1: reset state
    rd(6'd0, "R1 reg0 after reset");
    rd(6'd63, "R1 reg63 after reset");

    // R2: table sweep
    for (int i = 0; i < 8; i++) gwrite(VEC[i][37:32], VEC[i][31:0]);
    for (int i = 0; i < 8; i++) rd(VEC[i][37:32], "R2 general readback");

    // R2: same-cycle read returns old value
    gr_addr = 6'd15; gw_en = 1; gw_addr = 6'd15; gw_data = 32'h0BAD_0BAD; #1;
    chk("R2 old value during write", {32'h0, gr_data}, {32'h0, m[15]});
    tick(); gw_en = 0; m[15] = 32'h0BAD_0BAD;
    rd(6'd15, "R2 new value after edge");

    // R3: single float view
    fs_addr = 6'd15; #1;
    chk("R3 fs15 alias", {31'h0, fs_err, fs_data}, {31'h0, 1'b0, m[15]});
    fs_addr = 6'd32; #1;
    chk("R3 fs32 alias", {31'h0, fs_err, fs_data}, {31'h0, 1'b0, m[32]});
    fs_addr = 6'd16; #1;
    chk("R3 fs16 invalid", {31'h0, fs_err, fs_data}, {31'h0, 1'b1, 32'h0});
    fs_addr = 6'd63; #1;
    chk("R3 fs63 invalid", {31'h0, fs_err, fs_data}, {31'h0, 1'b1, 32'h0});

    // R4: double read view
    dr_addr = 6'd0; #1;
    chk("R4 dr0 pair", dr_data, {m[0], m[16]});
    dr_addr = 6'd47; #1;
    chk("R4 dr47 pair", dr_data, {m[47], m[63]});
    dr_addr = 6'd20; #1;
    chk("R4 dr20 invalid", {63'h0, dr_err}, 64'h1);
    chk("R4 dr20 zero data", dr_data, 64'h0);

    // R5: double write, same-cycle read sees old pair
    dr_addr = 6'd15; dw_en = 1; dw_addr = 6'd15; dw_data = 64'hA5A5_0015_5A5A_0031; #1;
    chk("R5 old pair during write", dr_data, {m[15], m[31]});
    tick(); dw_en = 0; m[15] = 32'hA5A5_0015; m[31] = 32'h5A5A_0031;
    rd(6'd15, "R5 upper word");
    rd(6'd31, "R5 lower word");

    // R6: invalid double write
    dw_en = 1; dw_addr = 6'd16; dw_data = 64'h1234_5678_9ABC_DEF0; #1;
    chk("R6 dw_err raised", {63'h0, dw_err}, 64'h1);
    tick(); dw_en = 0; #1;
    chk("R6 dw_err clears", {63'h0, dw_err}, 64'h0);
    rd(6'd16, "R6 reg16 unchanged");
    rd(6'd32, "R6 reg32 unchanged");
    rd(6'd0, "R6 reg0 unchanged");

    // R7: collisions on both halves
    gw_en = 1; gw_addr = 6'd47; gw_data = 32'h0000_00AA;
    dw_en = 1; dw_addr = 6'd47; dw_data = 64'hCAFE_0047_BEEF_0063;
    tick(); gw_en = 0; dw_en = 0; m[47] = 32'hCAFE_0047; m[63] = 32'hBEEF_0063;
    rd(6'd47, "R7 upper collision");
    gw_en = 1; gw_addr = 6'd48; gw_data = 32'h0000_00BB;
    dw_en = 1; dw_addr = 6'd32; dw_data = 64'h7777_0032_6666_0048;
    tick(); gw_en = 0; dw_en = 0; m[32] = 32'h7777_0032; m[48] = 32'h6666_0048;
    rd(6'd48, "R7 lower collision");
    rd(6'd32, "R7 upper with lower clash");

    // R8: base and index ports
    base_addr = 4'd15; idx_addr = 4'd0; #1;
    chk("R8 base15", {32'h0, base_data}, {32'h0, m[15]});
    chk("R8 idx0", {32'h0, idx_data}, {32'h0, m[0]});

    // R9: modification port
    mod_addr = 4'd15; #1;
    chk("R9 mod15", {32'h0, mod_data}, {32'h0, m[31]});
    mod_addr = 4'd0; #1;
    chk("R9 mod0", {32'h0, mod_data}, {32'h0, m[16]});

    // R1: reset again clears everything
    rst = 1; tick(); rst = 0;
    for (int i = 0; i < 64; i++) m[i] = '0;
    rd(6'd63, "R1 reg63 after second reset");
    dr_addr = 6'd32; #1;
    chk("R1 double view after reset", dr_data, 64'h0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule